// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a small 32-bit processor core that runs one instruction at a time. A control state machine steps each instruction through up to five phases: fetch, decode with operand read, execute, memory and write-back. A dedicated holding register keeps each intermediate value between phases: the instruction word, the next sequential address, the two operands, the extended immediate, the ALU result, the loaded word and the branch decision. The core owns a 32-entry general register file. Register 0 is hardwired to zero.

Instructions and data share a single word-addressed memory port. The port has one address bus, a read strobe, a write strobe and separate read and write data buses. Memory read data is combinational: a word must be valid on `mem_rdata_i` in the same cycle that `mem_rd_o` is high. The core computes byte addresses internally and presents bits `[AW+1:2]` of them on the port.

Each instruction word uses fixed fields. The opcode sits in bits 31:26 and the first source register in bits 25:21. Bits 20:16 hold the second source register, which is also the destination for immediate and load forms. Bits 15:11 hold the register-register destination, bits 15:0 the immediate and bits 10:0 the function code. Each instruction class uses only the phases it needs, so an instruction takes three, four or five cycles.

Top module: `cpu_core`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the core presents a fetch of word 0: `mem_rd_o` is 1, `mem_wr_o` is 0 and `mem_addr_o` is 0.
- R2: In a fetch cycle the core reads the word at byte address PC (port address PC>>2). Every fetch cycle is followed by a decode cycle. Without a taken branch, successive fetches use consecutive word addresses (PC+4).
- R3: Fetch-to-fetch spacing depends on the instruction class. Register-register and register-immediate instructions take 4 cycles, loads take 5, stores take 4, branches take 4 and unrecognised opcodes take 3.
- R4: Opcode 0x00 is register-register. It computes rs1 op rs2, where rs1 is bits 25:21 and rs2 is bits 20:16, and writes the result to the register in bits 15:11. The function code in bits 10:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed less-than (result 1 or 0). Any other function code adds.
- R5: Register-immediate opcodes are 0x08 add, 0x0C and, 0x0D or and 0x0E xor. Each combines rs1 with bits 15:0 sign-extended to 32 bits, including for the logical forms, and writes the result to the register in bits 20:16.
- R6: Opcode 0x23 loads a word. The byte address is rs1 + sign-extended bits 15:0. It is read in the memory cycle, and the word is written to the register in bits 20:16.
- R7: Opcode 0x2B stores the register in bits 20:16 to the word at rs1 + sign-extended bits 15:0, with `mem_wr_o` high for exactly one cycle. No other opcode asserts `mem_wr_o`.
- R8: Opcode 0x04 branches when rs1 equals zero, and opcode 0x05 branches when rs1 is non-zero. A taken branch continues at (address of the branch + 4) + sign-extended bits 15:0. A branch that is not taken continues at the next word.
- R9: Register 0 reads as zero, and writes that name it have no effect.
- R10: Any other opcode changes no register and no memory word, and execution continues at the next word.
- R11: `mem_rd_o` and `mem_wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | AW | Word address for fetch, load or store |
| mem_rd_o | output | 1 | Read strobe; data expected on mem_rdata_i in the same cycle |
| mem_wr_o | output | 1 | Write strobe for a store |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data (instruction or load word) |

## Verification
The bench builds the core with `AW = 10`, which gives a 1024-word memory. Programs sit in the low words, and data sits at byte offsets from 2048 upward. Those offsets still fit the 16-bit signed immediate. Loads and stores can therefore reach the data area both through a zero base register with a large positive offset and through a base register with a negative offset. The same narrow port also lets the bench tell fetch reads apart from load reads by address. This separation lets it measure cycle counts per instruction class and confirm that the halt branch jumps backwards onto itself.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int XLEN = 32;
  localparam int RFW  = 5;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_BNEZ = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  typedef enum logic [2:0] {ST_IF, ST_ID, ST_EX, ST_MEM, ST_WB} state_e;
  typedef enum logic [2:0] {CL_RR, CL_RI, CL_LD, CL_ST, CL_BR, CL_NOP} iclass_e;
  typedef enum logic [2:0] {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLT} alu_fn_e;

  function automatic iclass_e classify(input logic [5:0] op);
    case (op)
      OP_RR:                             return CL_RR;
      OP_ADDI, OP_ANDI, OP_ORI, OP_XORI: return CL_RI;
      OP_LW:                             return CL_LD;
      OP_SW:                             return CL_ST;
      OP_BEQZ, OP_BNEZ:                  return CL_BR;
      default:                           return CL_NOP;
    endcase
  endfunction

  function automatic alu_fn_e pick_fn(input logic [5:0] op, input logic [10:0] fn);
    if (op == OP_RR) begin
      case (fn)
        11'h022: return FN_SUB;
        11'h024: return FN_AND;
        11'h025: return FN_OR;
        11'h026: return FN_XOR;
        11'h02A: return FN_SLT;
        default: return FN_ADD;
      endcase
    end
    case (op)
      OP_ANDI: return FN_AND;
      OP_ORI:  return FN_OR;
      OP_XORI: return FN_XOR;
      default: return FN_ADD;
    endcase
  endfunction
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o
);
  logic [W-1:0] rf_q [NREG];

  always_ff @(posedge clk_i) begin
    if (we_i && (wa_i != '0)) rf_q[wa_i] <= wd_i;
  end

  // entry 0 is never written and never read
  assign rd1_o = (ra1_i == '0) ? '0 : rf_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : rf_q[ra2_i];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (fn_i)
      FN_SUB:  y_o = a_i - b_i;
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_XOR:  y_o = a_i ^ b_i;
      FN_SLT:  y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  iclass_e cls_i,
  output state_e  state_o,
  output logic    last_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IF: state_d = ST_ID;
      ST_ID: state_d = ST_EX;
      ST_EX: begin
        case (cls_i)
          CL_RR, CL_RI:        state_d = ST_WB;
          CL_LD, CL_ST, CL_BR: state_d = ST_MEM;
          default:             state_d = ST_IF;
        endcase
      end
      ST_MEM: state_d = (cls_i == CL_LD) ? ST_WB : ST_IF;
      default: state_d = ST_IF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign last_o  = (state_q != ST_IF) && (state_d == ST_IF);
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i
);
  localparam int NREG = 1 << RFW;

  logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_out_q, lmd_q;
  logic            cond_q;

  state_e  state;
  logic    last;
  iclass_e cls;
  alu_fn_e fn;

  logic [5:0]      opcode;
  logic [RFW-1:0]  rs1, rs2, rd_rr, wa;
  logic [XLEN-1:0] rf_rd1, rf_rd2, wd, alu_a, alu_b, alu_y;
  logic            taken_now;

  // fixed-field decode
  assign opcode = ir_q[31:26];
  assign rs1    = ir_q[25:21];
  assign rs2    = ir_q[20:16];
  assign rd_rr  = ir_q[15:11];
  assign cls    = classify(opcode);
  assign fn     = (cls == CL_RR || cls == CL_RI) ? pick_fn(opcode, ir_q[10:0]) : FN_ADD;

  cpu_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cls_i  (cls),
    .state_o(state),
    .last_o (last)
  );

  assign wa = (cls == CL_RR) ? rd_rr : rs2;
  assign wd = (cls == CL_LD) ? lmd_q : alu_out_q;

  cpu_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk_i (clk_i),
    .ra1_i (rs1),
    .ra2_i (rs2),
    .we_i  (state == ST_WB),
    .wa_i  (wa),
    .wd_i  (wd),
    .rd1_o (rf_rd1),
    .rd2_o (rf_rd2)
  );

  // one adder serves ALU ops, effective addresses and branch targets
  assign alu_a = (cls == CL_BR) ? npc_q : a_q;
  assign alu_b = (cls == CL_RR) ? b_q : imm_q;

  cpu_alu #(.W(XLEN)) u_alu (
    .a_i (alu_a),
    .b_i (alu_b),
    .fn_i(fn),
    .y_o (alu_y)
  );

  assign taken_now = (opcode == OP_BEQZ) ? (a_q == '0) : (a_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q      <= '0;
      npc_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      imm_q     <= '0;
      alu_out_q <= '0;
      lmd_q     <= '0;
      cond_q    <= 1'b0;
    end else begin
      case (state)
        ST_IF: begin
          ir_q  <= mem_rdata_i;
          npc_q <= pc_q + XLEN'(4);
        end
        ST_ID: begin
          a_q   <= rf_rd1;
          b_q   <= rf_rd2;
          imm_q <= {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
        end
        ST_EX: begin
          alu_out_q <= alu_y;
          cond_q    <= (cls == CL_BR) && taken_now;
        end
        ST_MEM: begin
          if (cls == CL_LD) lmd_q <= mem_rdata_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else if (last) pc_q <= (cls == CL_BR && cond_q) ? alu_out_q : npc_q;
  end

  assign mem_rd_o    = (state == ST_IF) || (state == ST_MEM && cls == CL_LD);
  assign mem_wr_o    = (state == ST_MEM) && (cls == CL_ST);
  assign mem_addr_o  = (state == ST_IF) ? pc_q[AW+1:2] : alu_out_q[AW+1:2];
  assign mem_wdata_o = b_q;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
  import cpu_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_rd_i,
  input logic        mem_wr_i,
  input state_e      state_i,
  input logic [31:0] ir_i,
  input logic [31:0] a_i,
  input logic [31:0] pc_i
);
  assert_rd_wr_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_i && mem_wr_i));

  assert_fetch_then_decode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IF) |=> (state_i == ST_ID));

  assert_store_then_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |=> (mem_rd_i && state_i == ST_IF));

  assert_wr_only_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |-> (ir_i[31:26] == OP_SW));

  assert_pc_held_early_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IF || state_i == ST_ID) |=> $stable(pc_i));

  assert_r0_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EX && ir_i[25:21] == 5'd0) |-> (a_i == 32'd0));
endmodule

bind cpu_core cpu_core_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mem_rd_i(mem_rd_o),
  .mem_wr_i(mem_wr_o),
  .state_i (state),
  .ir_i    (ir_q),
  .a_i     (a_q),
  .pc_i    (pc_q)
);

// File: tb/cpu_core_tb.sv
`timescale 1ns/1ps
module cpu_core_tb;
  localparam int AW = 10;
  localparam int MW = 1 << AW;
  localparam logic [15:0] HALT_OFS = 16'hFFFC;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [31:0]   mem_wdata, mem_rdata;

  logic [31:0] mem [MW];
  logic          ld_en = 1'b0, clr_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;

  int checks = 0, errors = 0;
  int cyc, nf, nwr;
  int fc [64];
  logic [AW-1:0] fa [64];
  logic [AW-1:0] last_fa;
  bit overlap_seen = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_core #(.AW(AW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mem_addr_o (mem_addr),
    .mem_rd_o   (mem_rd),
    .mem_wr_o   (mem_wr),
    .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (clr_en) begin
      for (int i = 0; i < MW; i++) mem[i] <= 32'd0;
    end else if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      cyc = 0; nf = 0; nwr = 0;
    end else begin
      if (mem_rd && mem_wr) overlap_seen = 1'b1;
      if (mem_wr) nwr++;
      if (mem_rd && mem_addr < AW'(256)) begin
        if (nf < 64) begin fc[nf] = cyc; fa[nf] = mem_addr; nf++; end
        last_fa = mem_addr;
      end
      cyc++;
    end
  end

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [10:0] f);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), f};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] d);
    ld_addr = AW'(a); ld_data = d; ld_en = 1'b1;
    @(posedge clk); #1 ld_en = 1'b0;
  endtask

  task automatic begin_test();
    @(negedge clk); rst_ni = 1'b0;
    clr_en = 1'b1; @(posedge clk); #1 clr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (2) @(posedge clk);
    #2 rst_ni = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    begin_test();
    put_word(0, enc_i(6'h04, 0, 0, HALT_OFS));
    @(negedge clk);
    chk(mem_rd && !mem_wr && mem_addr == 0, "R1 in reset", {mem_addr, mem_rd, mem_wr}, {10'd0, 2'b10});
    @(posedge clk); #2 rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_rd === 1'b1, "R1 rd after reset", 32'(mem_rd), 32'd1);
    chk(mem_wr === 1'b0, "R1 wr after reset", 32'(mem_wr), 32'd0);
    chk(mem_addr == 0, "R1 addr after reset", 32'(mem_addr), 32'd0);
  endtask

  task automatic t_rr_alu();
    logic [31:0] x, y;
    x = 32'd100; y = 32'hFFFF_FFF9;
    begin_test();
    put_word(0, enc_i(6'h08, 0, 1, 16'd100));
    put_word(1, enc_i(6'h08, 0, 2, 16'hFFF9));
    put_word(2, enc_r(1, 2, 3, 11'h020));
    put_word(3, enc_r(1, 2, 4, 11'h022));
    put_word(4, enc_r(1, 2, 5, 11'h024));
    put_word(5, enc_r(1, 2, 6, 11'h025));
    put_word(6, enc_r(1, 2, 7, 11'h026));
    put_word(7, enc_r(2, 1, 8, 11'h02A));
    put_word(8, enc_r(1, 2, 9, 11'h02A));
    for (int k = 0; k < 7; k++) put_word(9 + k, enc_i(6'h2B, 0, 3 + k, 16'(2048 + 4*k)));
    put_word(16, enc_i(6'h04, 0, 0, HALT_OFS));
    run(200);
    chk(mem[512] == x + y, "R4 add", mem[512], x + y);
    chk(mem[513] == x - y, "R4 sub", mem[513], x - y);
    chk(mem[514] == (x & y), "R4 and", mem[514], x & y);
    chk(mem[515] == (x | y), "R4 or", mem[515], x | y);
    chk(mem[516] == (x ^ y), "R4 xor", mem[516], x ^ y);
    chk(mem[517] == 32'd1, "R4 slt true", mem[517], 32'd1);
    chk(mem[518] == 32'd0, "R4 slt false", mem[518], 32'd0);
  endtask

  task automatic t_imm();
    begin_test();
    put_word(0, enc_i(6'h08, 0, 1, 16'h7FFF));
    put_word(1, enc_i(6'h0C, 1, 2, 16'h8F0F));
    put_word(2, enc_i(6'h0D, 0, 3, 16'h8001));
    put_word(3, enc_i(6'h0E, 1, 4, 16'hFFFF));
    put_word(4, enc_i(6'h08, 1, 5, 16'h8000));
    for (int k = 0; k < 5; k++) put_word(5 + k, enc_i(6'h2B, 0, 1 + k, 16'(2048 + 4*k)));
    put_word(10, enc_i(6'h04, 0, 0, HALT_OFS));
    run(200);
    chk(mem[512] == 32'h0000_7FFF, "R5 addi", mem[512], 32'h0000_7FFF);
    chk(mem[513] == 32'h0000_0F0F, "R5 andi sext", mem[513], 32'h0000_0F0F);
    chk(mem[514] == 32'hFFFF_8001, "R5 ori sext", mem[514], 32'hFFFF_8001);
    chk(mem[515] == 32'hFFFF_8000, "R5 xori sext", mem[515], 32'hFFFF_8000);
    chk(mem[516] == 32'hFFFF_FFFF, "R5 addi negative", mem[516], 32'hFFFF_FFFF);
  endtask

  task automatic t_load_store();
    begin_test();
    put_word(600, 32'hDEAD_BEEF);
    put_word(601, 32'h1234_5678);
    put_word(0, enc_i(6'h08, 0, 1, 16'd2408));
    put_word(1, enc_i(6'h23, 1, 2, 16'hFFF8));
    put_word(2, enc_i(6'h23, 1, 3, 16'hFFFC));
    put_word(3, enc_i(6'h2B, 1, 2, 16'd0));
    put_word(4, enc_i(6'h2B, 1, 3, 16'd4));
    put_word(5, enc_i(6'h2B, 1, 2, 16'hFFF4));
    put_word(6, enc_i(6'h04, 0, 0, HALT_OFS));
    run(200);
    chk(mem[602] == 32'hDEAD_BEEF, "R6 load neg offset", mem[602], 32'hDEAD_BEEF);
    chk(mem[603] == 32'h1234_5678, "R7 store pos offset", mem[603], 32'h1234_5678);
    chk(mem[599] == 32'hDEAD_BEEF, "R7 store neg offset", mem[599], 32'hDEAD_BEEF);
    chk(mem[604] == 32'd0, "R7 neighbour untouched", mem[604], 32'd0);
    chk(nwr == 3, "R7 one write per store", 32'(nwr), 32'd3);
  endtask

  task automatic t_branch();
    begin_test();
    for (int k = 0; k < 4; k++) put_word(512 + k, 32'hFFFF_FFFF);
    put_word(0, enc_i(6'h08, 0, 1, 16'd5));
    for (int k = 0; k < 4; k++) put_word(1 + k, enc_i(6'h08, 0, 10 + k, 16'd0));
    put_word(5,  enc_i(6'h04, 0, 0, 16'd4));
    put_word(6,  enc_i(6'h08, 0, 10, 16'd1));
    put_word(7,  enc_i(6'h04, 1, 0, 16'd4));
    put_word(8,  enc_i(6'h08, 0, 11, 16'd1));
    put_word(9,  enc_i(6'h05, 1, 0, 16'd4));
    put_word(10, enc_i(6'h08, 0, 12, 16'd1));
    put_word(11, enc_i(6'h05, 0, 0, 16'd4));
    put_word(12, enc_i(6'h08, 0, 13, 16'd1));
    for (int k = 0; k < 4; k++) put_word(13 + k, enc_i(6'h2B, 0, 10 + k, 16'(2048 + 4*k)));
    put_word(17, enc_i(6'h04, 0, 0, HALT_OFS));
    run(260);
    chk(mem[512] == 32'd0, "R8 beqz taken skips", mem[512], 32'd0);
    chk(mem[513] == 32'd1, "R8 beqz not taken", mem[513], 32'd1);
    chk(mem[514] == 32'd0, "R8 bnez taken skips", mem[514], 32'd0);
    chk(mem[515] == 32'd1, "R8 bnez not taken", mem[515], 32'd1);
    chk(last_fa == AW'(17), "R8 backward branch to self", 32'(last_fa), 32'd17);
  endtask

  task automatic t_r0();
    begin_test();
    put_word(512, 32'hFFFF_FFFF);
    put_word(0, enc_i(6'h08, 0, 0, 16'd55));
    put_word(1, enc_r(0, 0, 0, 11'h026));
    put_word(2, enc_i(6'h2B, 0, 0, 16'd2048));
    put_word(3, enc_i(6'h08, 0, 1, 16'd9));
    put_word(4, enc_i(6'h2B, 0, 1, 16'd2052));
    put_word(5, enc_i(6'h04, 0, 0, HALT_OFS));
    run(120);
    chk(mem[512] == 32'd0, "R9 r0 write ignored", mem[512], 32'd0);
    chk(mem[513] == 32'd9, "R9 r0 reads zero", mem[513], 32'd9);
  endtask

  task automatic t_timing();
    int exp_gap [6] = '{4, 5, 4, 4, 3, 4};
    begin_test();
    put_word(512, 32'hA5A5_0001);
    put_word(0, enc_i(6'h08, 0, 1, 16'd2048));
    put_word(1, enc_i(6'h23, 1, 2, 16'd0));
    put_word(2, enc_i(6'h2B, 1, 2, 16'd4));
    put_word(3, enc_i(6'h04, 1, 0, 16'd8));
    put_word(4, enc_i(6'h3F, 1, 2, 16'h0000));
    put_word(5, enc_i(6'h2B, 1, 2, 16'd8));
    put_word(6, enc_i(6'h04, 0, 0, HALT_OFS));
    run(100);
    for (int k = 0; k < 6; k++)
      chk(fc[k+1] - fc[k] == exp_gap[k], $sformatf("R3 gap %0d", k),
          32'(fc[k+1] - fc[k]), 32'(exp_gap[k]));
    for (int k = 0; k < 7; k++)
      chk(fa[k] == AW'(k), $sformatf("R2 fetch order %0d", k), 32'(fa[k]), 32'(k));
    chk(mem[514] == 32'hA5A5_0001, "R10 unknown op keeps reg", mem[514], 32'hA5A5_0001);
    chk(nwr == 2, "R10 unknown op no write", 32'(nwr), 32'd2);
    chk(!overlap_seen, "R11 rd/wr exclusive", 32'(overlap_seen), 32'd0);
  endtask

  initial begin
    t_reset();
    t_rr_alu();
    t_imm();
    t_load_store();
    t_branch();
    t_r0();
    t_timing();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule